// File: doc/BRIEF.md
# Switch Forwarding Mask Resolver

This block produces the final egress decision for one frame inside a small Ethernet switch analyzer. The switch has six front ports and one CPU port, and the CPU port is the top bit of every seven-bit port mask. For each frame the block reads three masks from a configurable table. The destination mask comes first and is chosen by the frame's lookup class. The aggregation mask comes second and is chosen by a supplied aggregation index. The source mask comes last and is chosen by the ingress port. The block combines the three masks into a front-port forward vector and a CPU-copy flag.

The CPU bit follows its own rule. It is the AND of the CPU bits of the destination and aggregation masks only: the source mask does not filter it, and the storm policer does not stop it. The front-port bits need all three masks to agree, and a storm-policer drop clears all of them. Software writes the table through a simple address/data/write-enable port. The resolved vector is registered and appears one clock after the frame strobe, with a one-cycle valid pulse.

A two-state controller sequences the output. In state IDLE no result is presented. The transition "frame accepted" moves from IDLE to RESULT when the strobe is high. In state RESULT the registered result is shown with the valid pulse. The transition "next frame" stays in RESULT when the strobe is high again, and the transition "drain" returns to IDLE when it is low.

Top module: `fmr_resolver`

## Requirements
- R1: `res_valid` is high exactly in the cycle after a cycle with `frm_valid` high, and the result of that frame is presented in that cycle. While `res_valid` is low, `res_fwd` and `res_cpu` are zero.
- R2: Each front bit p (0..5) of `res_fwd` is the AND of bit p of the destination mask, the aggregation mask and the source mask.
- R3: `res_cpu` is the AND of bit 6 of the destination mask and bit 6 of the aggregation mask. Bit 6 of the source mask has no effect on it.
- R4: The destination entry is chosen by `frm_cls`. Code 0 (known unicast) uses `frm_idx` directly. Code 1 (unknown unicast) uses entry 60. Code 2 (multicast/broadcast) and the reserved code 3 use entry 61. The aggregation entry is `frm_aggr`, read from the same 64-entry table.
- R5: After reset, entry 60 holds 0x3F and every other group entry, including entry 61, holds 0x7F. The source entry for ingress port p (0..6) holds 0x7F with bit p cleared.
- R6: When `storm_drop` is high with a frame, `res_fwd` is zero and `res_cpu` still follows R3.
- R7: A write with `cfg_addr` 0..63 sets that group entry. A write to 64+p sets the source entry of port p, for p = 0..6. Writes to 71..127 change no entry.
- R8: A table write in the same cycle as a frame strobe takes effect after that frame: the frame is resolved with the previous contents.
- R9: A frame with ingress port 7 (out of range) gets an all-zero front vector. Its CPU copy still follows R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | Frame lookup strobe |
| frm_cls | input | 2 | Lookup class: 0 known UC, 1 unknown UC, 2 MC/BC, 3 reserved (as MC) |
| frm_idx | input | 6 | Destination table index for known unicast |
| frm_aggr | input | 6 | Aggregation table index |
| frm_port | input | 3 | Ingress port, 0..5 front, 6 CPU |
| storm_drop | input | 1 | Storm-policer drop flag |
| cfg_we | input | 1 | Table write enable |
| cfg_addr | input | 7 | Table write address |
| cfg_wdata | input | 7 | Table write data, bit 6 = CPU |
| res_valid | output | 1 | Result valid pulse |
| res_fwd | output | 6 | Front-port forward vector |
| res_cpu | output | 1 | CPU-copy flag |

## Verification
The combine rule is tried with three kinds of input pattern. In the first, destination, aggregation and source masks each clear a different front bit, which shows that all three are ANDed. In the second, only the aggregation mask drops the CPU bit, while frames from the CPU port leave its own source bit clear, which separates the CPU rule from the front rule. In the third, the storm flag is raised on frames with and without the CPU bit in the destination mask, which shows that the policer blocks only front forwarding. Write-address boundaries (63, 64+p, beyond 70) and a write in the same cycle as a lookup separate correct decoding and ordering from aliasing or bypass.

// File: rtl/fmr_pkg.sv
package fmr_pkg;
    localparam int FRONT_PORTS_DEF = 6;
    localparam int GROUP_DEPTH_DEF = 64;
    localparam int UC_FLOOD_DEF    = 60;
    localparam int MC_FLOOD_DEF    = 61;

    typedef enum logic [1:0] {
        LK_KNOWN_UC   = 2'd0,
        LK_UNKNOWN_UC = 2'd1,
        LK_MCAST      = 2'd2,
        LK_RESERVED   = 2'd3
    } lookup_cls_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } res_state_e;
endpackage

// File: rtl/fmr_mask_table.sv
module fmr_mask_table #(
    parameter int NUM_FRONT   = 6,
    parameter int GROUP_DEPTH = 64,
    parameter int UC_FLOOD    = 60,
    localparam int MASK_W    = NUM_FRONT + 1,
    localparam int NUM_PORTS = NUM_FRONT + 1,
    localparam int GIDX_W    = $clog2(GROUP_DEPTH),
    localparam int PORT_W    = $clog2(NUM_PORTS + 1),
    localparam int ADDR_W    = $clog2(GROUP_DEPTH + NUM_PORTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [MASK_W-1:0] wr_data,
    input  logic [GIDX_W-1:0] dst_addr,
    input  logic [GIDX_W-1:0] agg_addr,
    input  logic [PORT_W-1:0] src_port,
    output logic [MASK_W-1:0] dst_mask,
    output logic [MASK_W-1:0] agg_mask,
    output logic [MASK_W-1:0] src_mask
);
    localparam logic [MASK_W-1:0] ALL_PORTS  = {MASK_W{1'b1}};
    localparam logic [MASK_W-1:0] FRONT_ONLY = {1'b0, {NUM_FRONT{1'b1}}};

    logic [MASK_W-1:0] grp_q [GROUP_DEPTH];
    logic [MASK_W-1:0] src_q [NUM_PORTS];
    logic [ADDR_W-1:0] src_off;

    assign src_off = wr_addr - ADDR_W'(GROUP_DEPTH);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < GROUP_DEPTH; i++)
                grp_q[i] <= (i == UC_FLOOD) ? FRONT_ONLY : ALL_PORTS;
        end else if (wr_en && (wr_addr < ADDR_W'(GROUP_DEPTH))) begin
            grp_q[wr_addr[GIDX_W-1:0]] <= wr_data;
        end
    end

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_src
            always_ff @(posedge clk) begin
                if (!rst_n)
                    src_q[p] <= ALL_PORTS & ~(MASK_W'(1) << p);
                else if (wr_en && (wr_addr >= ADDR_W'(GROUP_DEPTH))
                         && (src_off == ADDR_W'(p)))
                    src_q[p] <= wr_data;
            end
        end
    endgenerate

    assign dst_mask = grp_q[dst_addr];
    assign agg_mask = grp_q[agg_addr];

    always_comb begin
        if (src_port < PORT_W'(NUM_PORTS))
            src_mask = src_q[src_port];
        else
            src_mask = '0;
    end
endmodule

// File: rtl/fmr_combine.sv
module fmr_combine #(
    parameter int NUM_FRONT = 6,
    localparam int MASK_W = NUM_FRONT + 1
) (
    input  logic [MASK_W-1:0]    dst_mask,
    input  logic [MASK_W-1:0]    agg_mask,
    input  logic [MASK_W-1:0]    src_mask,
    input  logic                 drop,
    output logic [NUM_FRONT-1:0] fwd,
    output logic                 cpu
);
    generate
        for (genvar b = 0; b < NUM_FRONT; b++) begin : g_front
            assign fwd[b] = dst_mask[b] & agg_mask[b] & src_mask[b] & ~drop;
        end
    endgenerate

    // CPU bit: two lookups only, immune to the storm policer
    assign cpu = dst_mask[NUM_FRONT] & agg_mask[NUM_FRONT];
endmodule

// File: rtl/fmr_resolver.sv
module fmr_resolver
    import fmr_pkg::*;
#(
    parameter int NUM_FRONT   = FRONT_PORTS_DEF,
    parameter int GROUP_DEPTH = GROUP_DEPTH_DEF,
    parameter int UC_FLOOD    = UC_FLOOD_DEF,
    parameter int MC_FLOOD    = MC_FLOOD_DEF
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          frm_valid,
    input  logic [1:0]                                    frm_cls,
    input  logic [$clog2(GROUP_DEPTH)-1:0]                frm_idx,
    input  logic [$clog2(GROUP_DEPTH)-1:0]                frm_aggr,
    input  logic [$clog2(NUM_FRONT+2)-1:0]                frm_port,
    input  logic                                          storm_drop,
    input  logic                                          cfg_we,
    input  logic [$clog2(GROUP_DEPTH+NUM_FRONT+1)-1:0]    cfg_addr,
    input  logic [NUM_FRONT:0]                            cfg_wdata,
    output logic                                          res_valid,
    output logic [NUM_FRONT-1:0]                          res_fwd,
    output logic                                          res_cpu
);
    localparam int MASK_W = NUM_FRONT + 1;
    localparam int GIDX_W = $clog2(GROUP_DEPTH);

    res_state_e        state_q, state_d;
    lookup_cls_e       cls;
    logic [GIDX_W-1:0] dst_addr;
    logic [MASK_W-1:0] dst_mask, agg_mask, src_mask;
    logic [NUM_FRONT-1:0] fwd_c;
    logic              cpu_c;

    assign cls = lookup_cls_e'(frm_cls);

    always_comb begin
        unique case (cls)
            LK_KNOWN_UC:   dst_addr = frm_idx;
            LK_UNKNOWN_UC: dst_addr = GIDX_W'(UC_FLOOD);
            LK_MCAST,
            LK_RESERVED:   dst_addr = GIDX_W'(MC_FLOOD);
        endcase
    end

    fmr_mask_table #(
        .NUM_FRONT(NUM_FRONT), .GROUP_DEPTH(GROUP_DEPTH), .UC_FLOOD(UC_FLOOD)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
        .dst_addr(dst_addr), .agg_addr(frm_aggr), .src_port(frm_port),
        .dst_mask(dst_mask), .agg_mask(agg_mask), .src_mask(src_mask)
    );

    fmr_combine #(.NUM_FRONT(NUM_FRONT)) u_comb (
        .dst_mask(dst_mask), .agg_mask(agg_mask), .src_mask(src_mask),
        .drop(storm_drop), .fwd(fwd_c), .cpu(cpu_c)
    );

    // next-state logic
    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = frm_valid ? ST_RESULT : ST_IDLE;   // frame accepted
            ST_RESULT: state_d = frm_valid ? ST_RESULT : ST_IDLE;   // next frame / drain
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n || !frm_valid) begin
            res_fwd <= '0;
            res_cpu <= 1'b0;
        end else begin
            res_fwd <= fwd_c;
            res_cpu <= cpu_c;
        end
    end

    assign res_valid = (state_q == ST_RESULT);
endmodule

// File: rtl/fmr_checker.sv
module fmr_checker #(
    parameter int NUM_FRONT = 6,
    parameter int PORT_W    = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 frm_valid,
    input logic [PORT_W-1:0]    frm_port,
    input logic                 storm_drop,
    input logic                 res_valid,
    input logic [NUM_FRONT-1:0] res_fwd,
    input logic                 res_cpu
);
    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> res_valid);

    assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_valid |=> !res_valid);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (res_fwd == '0) && !res_cpu);

    assert_storm_blocks_front_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && storm_drop |=> res_fwd == '0);

    assert_bad_port_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && (frm_port > PORT_W'(NUM_FRONT)) |=> res_fwd == '0);
endmodule

bind fmr_resolver fmr_checker #(
    .NUM_FRONT(NUM_FRONT), .PORT_W($clog2(NUM_FRONT+2))
) u_chk (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_port(frm_port),
    .storm_drop(storm_drop), .res_valid(res_valid), .res_fwd(res_fwd),
    .res_cpu(res_cpu)
);

// File: tb/sim_fmr_resolver.sv
module sim_fmr_resolver;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frm_valid = 1'b0;
    logic [1:0] frm_cls = '0;
    logic [5:0] frm_idx = '0, frm_aggr = '0;
    logic [2:0] frm_port = '0;
    logic       storm_drop = 1'b0;
    logic       cfg_we = 1'b0;
    logic [6:0] cfg_addr = '0, cfg_wdata = '0;
    logic       res_valid;
    logic [5:0] res_fwd;
    logic       res_cpu;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fmr_resolver u0 (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_cls(frm_cls),
        .frm_idx(frm_idx), .frm_aggr(frm_aggr), .frm_port(frm_port),
        .storm_drop(storm_drop), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .res_valid(res_valid), .res_fwd(res_fwd),
        .res_cpu(res_cpu)
    );

    // {cls, idx, aggr, port, drop, exp_fwd, exp_cpu}
    localparam int NV = 13;
    localparam logic [24:0] VEC [NV] = '{
        {2'd0, 6'd5,  6'd30, 3'd0, 1'b0, 6'h0A, 1'b1},  // R2 R4 known UC
        {2'd0, 6'd5,  6'd20, 3'd2, 1'b0, 6'h08, 1'b0},  // R2 R3 agg clears bits
        {2'd0, 6'd5,  6'd30, 3'd3, 1'b0, 6'h02, 1'b1},  // R2 source clears own bit
        {2'd1, 6'd0,  6'd30, 3'd1, 1'b0, 6'h3D, 1'b0},  // R4 R5 unknown UC
        {2'd2, 6'd0,  6'd30, 3'd5, 1'b0, 6'h1F, 1'b1},  // R4 R5 multicast
        {2'd2, 6'd0,  6'd20, 3'd0, 1'b0, 6'h3C, 1'b0},  // R3 agg removes CPU
        {2'd2, 6'd0,  6'd30, 3'd6, 1'b0, 6'h3F, 1'b1},  // R3 source bit6 ignored
        {2'd2, 6'd0,  6'd30, 3'd4, 1'b1, 6'h00, 1'b1},  // R6 storm, CPU kept
        {2'd1, 6'd0,  6'd30, 3'd0, 1'b1, 6'h00, 1'b0},  // R6 storm, no CPU
        {2'd0, 6'd10, 6'd30, 3'd7, 1'b0, 6'h00, 1'b0},  // R9 bad port
        {2'd0, 6'd10, 6'd30, 3'd5, 1'b0, 6'h0F, 1'b0},  // R2 entry 10
        {2'd3, 6'd0,  6'd30, 3'd2, 1'b0, 6'h3B, 1'b1},  // R4 reserved as MC
        {2'd0, 6'd0,  6'd60, 3'd1, 1'b0, 6'h3D, 1'b0}   // R5 agg entry 60
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [6:0] a, input logic [6:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic frame(input logic [1:0] c, input logic [5:0] i, input logic [5:0] g,
                         input logic [2:0] p, input logic d);
        @(negedge clk);
        frm_valid = 1'b1; frm_cls = c; frm_idx = i; frm_aggr = g;
        frm_port = p; storm_drop = d;
        @(negedge clk);
        frm_valid = 1'b0; storm_drop = 1'b0;
    endtask

    task automatic expect_res(input string req, input logic [5:0] f, input logic c);
        check(req, {1'b0, res_valid, res_fwd}, {2'b01, f});
        check(req, {7'd0, res_cpu}, {7'd0, c});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset", {res_valid, res_cpu, res_fwd}, 8'h00);

        frame(2'd2, 6'd0, 6'd0, 3'd0, 1'b0);          // R5 defaults
        expect_res("R5 default mc", 6'h3E, 1'b1);
        @(negedge clk);
        check("R1 idle after pulse", {res_valid, res_cpu, res_fwd}, 8'h00);

        cfg_write(7'd5,  7'h4A);
        cfg_write(7'd10, 7'h0F);
        cfg_write(7'd20, 7'h3D);

        for (int k = 0; k < NV; k++) begin
            frame(VEC[k][24:23], VEC[k][22:17], VEC[k][16:11], VEC[k][10:8], VEC[k][7]);
            expect_res($sformatf("R2 vector %0d", k), VEC[k][6:1], VEC[k][0]);
        end

        // R7: source entry write for port 1
        cfg_write(7'd65, 7'h7F);
        frame(2'd2, 6'd0, 6'd30, 3'd1, 1'b0);
        expect_res("R7 src write", 6'h3F, 1'b1);
        // R7: boundary entry 63 and out-of-range address
        cfg_write(7'd63, 7'h01);
        frame(2'd2, 6'd0, 6'd63, 3'd2, 1'b0);
        expect_res("R7 entry 63", 6'h01, 1'b0);
        cfg_write(7'd100, 7'h00);
        cfg_write(7'd127, 7'h00);
        frame(2'd0, 6'd36, 6'd30, 3'd2, 1'b0);
        expect_res("R7 ignored write", 6'h3B, 1'b1);
        frame(2'd2, 6'd0, 6'd30, 3'd6, 1'b0);
        expect_res("R7 src6 intact", 6'h3F, 1'b1);

        // R8: write coincident with lookup
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 7'd61; cfg_wdata = 7'h00;
        frm_valid = 1'b1; frm_cls = 2'd2; frm_aggr = 6'd30; frm_port = 3'd0;
        @(negedge clk);
        cfg_we = 1'b0; frm_valid = 1'b0;
        expect_res("R8 old contents", 6'h3E, 1'b1);
        frame(2'd2, 6'd0, 6'd30, 3'd0, 1'b0);
        expect_res("R8 new contents", 6'h00, 1'b0);

        // R1: back-to-back frames
        @(negedge clk);
        frm_valid = 1'b1; frm_cls = 2'd1; frm_aggr = 6'd30; frm_port = 3'd0;
        @(negedge clk);
        frm_port = 3'd5;
        expect_res("R1 b2b first", 6'h3E, 1'b0);
        @(negedge clk);
        frm_valid = 1'b0;
        expect_res("R1 b2b second", 6'h1F, 1'b0);
        @(negedge clk);
        check("R1 drain", {res_valid, res_cpu, res_fwd}, 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule